// File: doc/BRIEF.md
# Multi-Event ADC Data Packer

This block sits between the conversion logic of a multi-channel charge or peak ADC and its readout buffer. Each trigger strobe offers a snapshot of every channel: a 12-bit value, an under-threshold flag, an overflow flag, and a mask bit that says whether the channel should be kept. When the trigger is flagged for storage, the block captures the snapshot and sends it out as a run of 32-bit words. The run starts with a typed header, continues with one datum word per kept channel, and ends with a trailer that carries a running event number.

Channels are visited in an interleaved order that alternates between the lower and upper halves of the channel set. Masked channels produce no word. The event number advances on every accepted trigger, whether or not that trigger is stored, so a reader can tell how many triggers were dropped between two stored events. The output is a valid/ready stream with a last-word marker on the trailer. A new trigger is accepted only after the previous trailer has been taken.

Top module: `adc_event_packer`

## Requirements
- R1: Bits 26..24 of each output word give its type: 3'b010 for a header, 3'b000 for a datum, 3'b100 for a trailer.
- R2: A header carries `crate_id` (captured at the trigger) in bits 23..16 and the number of kept channels in bits 13..8. Bits 15..14 and 7..0 are zero.
- R3: A datum carries the channel number in bits 21..16, under-threshold in bit 13, overflow in bit 12, and the 12-bit value in bits 11..0. Bits 23..22 and 15..14 are zero.
- R4: A trailer carries the event number in bits 23..0. When the counter is narrower than 24 bits, the number is zero-extended.
- R5: Bits 31..27 of every word hold `geo_addr` as captured at the trigger.
- R6: A stored event appears as exactly one header, then one datum per kept channel, then one trailer. The header count equals the number of datum words. `word_last` is high only with the trailer.
- R7: Kept channels are emitted in slot order. For an even channel count N, slot k maps to channel k/2 when k is even and to channel N/2+(k-1)/2 when k is odd (0,16,1,17,...,15,31 for 32). Channels whose mask bit is 0 are skipped.
- R8: A stored event with an all-zero mask emits a header with count 0, followed directly by its trailer.
- R9: The event counter starts at 0 after reset. Each accepted trigger, stored or not (`trig_store`=0), puts the current counter value into that event's trailer and then adds one.
- R10: The event counter wraps from its all-ones value to zero.
- R11: `evt_cnt_clr` synchronously sets the event counter to zero.
- R12: While `word_valid` is high and `word_ready` is low, `word_data` and `word_last` hold their values and `word_valid` stays high.
- R13: A trigger that arrives before the current trailer has been accepted is ignored. It does not advance the counter and does not produce a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_cnt_clr | input | 1 | Synchronous clear of the event counter |
| trig | input | 1 | Trigger strobe, one cycle |
| trig_store | input | 1 | With `trig`: 1 stores the event, 0 only counts it |
| ch_mask | input | N_CH | Per-channel keep mask |
| ch_value | input | N_CH*12 | Per-channel converted values; channel c in bits [12c+11:12c] |
| ch_under | input | N_CH | Per-channel under-threshold flags |
| ch_over | input | N_CH | Per-channel overflow flags |
| crate_id | input | 8 | Crate number placed in headers |
| geo_addr | input | 5 | Module address placed in bits 31..27 |
| word_data | output | 32 | Output word |
| word_valid | output | 1 | Output word is valid |
| word_ready | input | 1 | Downstream accepts the word |
| word_last | output | 1 | Marks the trailer word |

## Verification
The in-RTL assertions check the following on every cycle:
- the word is held stable under back-pressure;
- the type code is legal;
- the last marker is tied to the trailer type;
- the reserved datum bits are zero;
- the counter steps by one or clears;
- the counter stays frozen while a busy block sees a trigger.

Other properties only emerge from the bench's scenarios, which compare every accepted word against a frame built arithmetically:
- the header count matching the datum words;
- the interleaved channel order;
- the skipping of masked channels;
- gaps in the event number left by unstored triggers;
- the counter wrap, shown on a narrow-counter instance.

// File: rtl/adcp_pkg.sv
package adcp_pkg;

  localparam int VAL_W = 12;

  localparam logic [2:0] TY_HDR = 3'b010;
  localparam logic [2:0] TY_DAT = 3'b000;
  localparam logic [2:0] TY_EOB = 3'b100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_DAT,
    ST_EOB,
    ST_DRAIN
  } pk_state_t;

  function automatic logic [31:0] mk_header(input logic [4:0] geo,
                                            input logic [7:0] crate,
                                            input logic [5:0] nch);
    return {geo, TY_HDR, crate, 2'b00, nch, 8'h00};
  endfunction

  function automatic logic [31:0] mk_datum(input logic [4:0] geo,
                                           input logic [5:0] chn,
                                           input logic       un,
                                           input logic       ov,
                                           input logic [VAL_W-1:0] val);
    return {geo, TY_DAT, 2'b00, chn, 2'b00, un, ov, val};
  endfunction

  function automatic logic [31:0] mk_trailer(input logic [4:0] geo,
                                             input logic [23:0] evn);
    return {geo, TY_EOB, evn};
  endfunction

endpackage

// File: rtl/adcp_evt_counter.sv
module adcp_evt_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  // R9 / R10: an accepted trigger steps the count by one, modulo 2^CNT_W
  a_r9_step: assert property (@(posedge clk) disable iff (rst)
    inc && !clr |=> cnt == $past(cnt) + 1'b1);

  // R11: clear lands as zero on the next cycle
  a_r11_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> cnt == '0);

endmodule

// File: rtl/adcp_popcount.sv
module adcp_popcount #(
  parameter int N   = 32,
  parameter int O_W = $clog2(N + 1)
) (
  input  logic [N-1:0]   bits,
  output logic [O_W-1:0] ones
);

  always_comb begin
    ones = '0;
    for (int i = 0; i < N; i++) ones = ones + O_W'(bits[i]);
  end

endmodule

// File: rtl/adcp_slot_map.sv
module adcp_slot_map #(
  parameter int N_CH = 32,
  parameter int CH_W = 5
) (
  input  logic [CH_W-1:0] slot,
  output logic [CH_W-1:0] chan
);

  generate
    if ((N_CH % 2) == 0) begin : g_interleave
      localparam int HALF = N_CH / 2;
      assign chan = slot[0] ? (CH_W'(HALF) + (slot >> 1)) : (slot >> 1);
    end else begin : g_linear
      assign chan = slot;
    end
  endgenerate

endmodule

// File: rtl/adc_event_packer.sv
module adc_event_packer
  import adcp_pkg::*;
#(
  parameter int N_CH  = 32,
  parameter int CNT_W = 24
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  evt_cnt_clr,
  input  logic                  trig,
  input  logic                  trig_store,
  input  logic [N_CH-1:0]       ch_mask,
  input  logic [N_CH*VAL_W-1:0] ch_value,
  input  logic [N_CH-1:0]       ch_under,
  input  logic [N_CH-1:0]       ch_over,
  input  logic [7:0]            crate_id,
  input  logic [4:0]            geo_addr,
  output logic [31:0]           word_data,
  output logic                  word_valid,
  input  logic                  word_ready,
  output logic                  word_last
);

  localparam int CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam int SLOT_W = $clog2(N_CH + 1);
  localparam int NUM_W  = $clog2(N_CH + 1);

  pk_state_t          state_q;
  logic [SLOT_W-1:0]  slot_q;
  logic [CH_W-1:0]    ch_idx;
  logic [NUM_W-1:0]   n_kept;
  logic [CNT_W-1:0]   evt_cnt;

  // snapshot of one event (plain registers, no reset needed on data)
  logic [N_CH-1:0]    mask_q;
  logic [VAL_W-1:0]   val_q [N_CH];
  logic [N_CH-1:0]    un_q;
  logic [N_CH-1:0]    ov_q;
  logic [7:0]         crate_q;
  logic [4:0]         geo_q;
  logic [CNT_W-1:0]   evnum_q;

  logic trig_ok, cap, fire, free, slot_end;

  assign trig_ok  = trig && (state_q == ST_IDLE);
  assign cap      = trig_ok && trig_store;
  assign fire     = word_valid && word_ready;
  assign free     = !word_valid || word_ready;
  assign slot_end = (slot_q == SLOT_W'(N_CH));

  adcp_evt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (evt_cnt_clr),
    .inc (trig_ok),
    .cnt (evt_cnt)
  );

  adcp_popcount #(.N(N_CH), .O_W(NUM_W)) u_pop (
    .bits (mask_q),
    .ones (n_kept)
  );

  adcp_slot_map #(.N_CH(N_CH), .CH_W(CH_W)) u_map (
    .slot (slot_q[CH_W-1:0]),
    .chan (ch_idx)
  );

  always_ff @(posedge clk) begin
    if (cap) begin
      mask_q  <= ch_mask;
      un_q    <= ch_under;
      ov_q    <= ch_over;
      crate_q <= crate_id;
      geo_q   <= geo_addr;
      evnum_q <= evt_cnt;
      for (int i = 0; i < N_CH; i++) val_q[i] <= ch_value[i*VAL_W +: VAL_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      slot_q     <= '0;
      word_data  <= '0;
      word_valid <= 1'b0;
      word_last  <= 1'b0;
    end else begin
      if (fire) begin
        word_valid <= 1'b0;
        word_last  <= 1'b0;
      end
      case (state_q)
        ST_IDLE: if (cap) state_q <= ST_HDR;
        ST_HDR: if (free) begin
          word_data  <= mk_header(geo_q, crate_q, 6'(n_kept));
          word_valid <= 1'b1;
          word_last  <= 1'b0;
          slot_q     <= '0;
          state_q    <= ST_DAT;
        end
        ST_DAT: begin
          if (slot_end) begin
            state_q <= ST_EOB;
          end else if (!mask_q[ch_idx]) begin
            slot_q <= slot_q + 1'b1;
          end else if (free) begin
            word_data  <= mk_datum(geo_q, 6'(ch_idx), un_q[ch_idx],
                                   ov_q[ch_idx], val_q[ch_idx]);
            word_valid <= 1'b1;
            word_last  <= 1'b0;
            slot_q     <= slot_q + 1'b1;
          end
        end
        ST_EOB: if (free) begin
          word_data  <= mk_trailer(geo_q, 24'(evnum_q));
          word_valid <= 1'b1;
          word_last  <= 1'b1;
          state_q    <= ST_DRAIN;
        end
        ST_DRAIN: if (fire) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  // R12: back-pressure freezes the presented word
  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    word_valid && !word_ready |=> word_valid && $stable(word_data) && $stable(word_last));

  // R1: only the three legal type codes leave the block
  a_r1_type: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> (word_data[26:24] == TY_HDR || word_data[26:24] == TY_DAT ||
                    word_data[26:24] == TY_EOB));

  // R6: last marker goes with the trailer type and nothing else
  a_r6_last: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> (word_last == (word_data[26:24] == TY_EOB)));

  // R3: reserved datum bits are zero
  a_r3_gaps: assert property (@(posedge clk) disable iff (rst)
    word_valid && word_data[26:24] == TY_DAT |-> word_data[23:22] == 2'b00 && word_data[15:14] == 2'b00);

  // R13: a trigger while a frame is in flight leaves the counter alone
  a_r13_busy: assert property (@(posedge clk) disable iff (rst)
    state_q != ST_IDLE && trig && !evt_cnt_clr |=> evt_cnt == $past(evt_cnt));

endmodule

// File: tb/adc_event_packer_bench.sv
module adc_event_packer_bench;

  localparam int N = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst, evt_cnt_clr, trig, trig_store, word_ready;
  logic [N-1:0]  ch_mask, ch_under, ch_over;
  logic [N*12-1:0] ch_value;
  logic [7:0]    crate_id;
  logic [4:0]    geo_addr;
  logic [31:0]   word_data;
  logic          word_valid, word_last;

  adc_event_packer u_adc_event_packer (
    .clk(clk), .rst(rst), .evt_cnt_clr(evt_cnt_clr), .trig(trig), .trig_store(trig_store),
    .ch_mask(ch_mask), .ch_value(ch_value), .ch_under(ch_under), .ch_over(ch_over),
    .crate_id(crate_id), .geo_addr(geo_addr), .word_data(word_data),
    .word_valid(word_valid), .word_ready(word_ready), .word_last(word_last));

  // narrow-counter, 4-channel configuration for the wrap case
  logic          s_trig, s_store;
  logic [3:0]    s_mask;
  logic [47:0]   s_value;
  logic [31:0]   s_data;
  logic          s_valid, s_last;

  adc_event_packer #(.N_CH(4), .CNT_W(4)) u_adc_event_packer_small (
    .clk(clk), .rst(rst), .evt_cnt_clr(1'b0), .trig(s_trig), .trig_store(s_store),
    .ch_mask(s_mask), .ch_value(s_value), .ch_under(4'h0), .ch_over(4'h0),
    .crate_id(8'h00), .geo_addr(5'h00), .word_data(s_data),
    .word_valid(s_valid), .word_ready(1'b1), .word_last(s_last));

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  logic [23:0] exp_cnt = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: got cycle %0d expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] vfun(input int c, input int s);
    return 12'((c * 97 + s * 131 + 5) % 4096);
  endfunction

  function automatic bit rdy(input int mode);
    case (mode)
      0: return 1'b1;
      1: return cyc[0];
      default: return (cyc % 3) != 0;
    endcase
  endfunction

  task automatic skip_trig();
    trig_store = 1'b0; trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    exp_cnt = exp_cnt + 1'b1;
  endtask

  task automatic run_event(input logic [31:0] mask, input int seed, input int rmode, input bit poke);
    logic [31:0] ew [0:33];
    int n;
    int idx;
    int wc;
    bit holding;
    logic [31:0] held;
    logic [4:0] g;
    logic [7:0] cr;
    g  = 5'(seed * 7 + 31);
    cr = 8'(seed * 29 + 3);
    ch_mask = mask; geo_addr = g; crate_id = cr;
    for (int c = 0; c < N; c++) begin
      ch_value[c*12 +: 12] = vfun(c, seed);
      ch_under[c] = ((c + seed) % 3) == 0;
      ch_over[c]  = ((c + seed) % 5) == 0;
    end
    trig_store = 1'b1; trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    // change inputs after capture: frame must still use the snapshot
    ch_mask = ~mask; geo_addr = ~g; crate_id = ~cr;
    n = 1;
    for (int k = 0; k < N; k++) begin
      int c;
      c = (k % 2 == 0) ? k / 2 : N / 2 + k / 2;
      if (mask[c]) begin
        ew[n] = {g, 3'b000, 2'b00, 6'(c), 2'b00, 1'(((c + seed) % 3) == 0),
                 1'(((c + seed) % 5) == 0), vfun(c, seed)};
        n++;
      end
    end
    ew[0] = {g, 3'b010, cr, 2'b00, 6'(n - 1), 8'h00};
    ew[n] = {g, 3'b100, exp_cnt};
    n++;
    exp_cnt = exp_cnt + 1'b1;
    idx = 0; wc = 0; holding = 0; held = '0;
    while (idx < n && wc < 2000) begin
      trig = poke && (wc == 3);
      word_ready = rdy(rmode);
      if (holding) begin
        chk("R12 valid held", 32'(word_valid), 32'd1);
        chk("R12 data held", word_data, held);
      end
      holding = 0;
      if (word_valid) begin
        if (word_ready) begin
          if (idx == 0)          chk("R1 R2 R5 header", word_data, ew[idx]);
          else if (idx == n - 1) chk("R4 R9 trailer", word_data, ew[idx]);
          else                   chk("R3 R7 datum", word_data, ew[idx]);
          chk("R6 last flag", 32'(word_last), 32'(idx == n - 1));
          idx++;
        end else begin
          holding = 1; held = word_data;
        end
      end
      @(negedge clk);
      wc++;
    end
    trig = 1'b0;
    chk("R6 frame complete", 32'(idx), 32'(n));
    for (int w = 0; w < 3; w++) begin
      chk("R13 no stray word", 32'(word_valid), 32'd0);
      @(negedge clk);
    end
  endtask

  initial begin
    rst = 1'b1; evt_cnt_clr = 1'b0; trig = 1'b0; trig_store = 1'b0; word_ready = 1'b1;
    ch_mask = '0; ch_under = '0; ch_over = '0; ch_value = '0; crate_id = '0; geo_addr = '0;
    s_trig = 1'b0; s_store = 1'b0; s_mask = 4'h0; s_value = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R6 reset idle", 32'(word_valid), 32'd0);
    chk("R6 reset last", 32'(word_last), 32'd0);

    // R7 full set, first event number 0 (R9)
    run_event(32'hFFFF_FFFF, 1, 0, 1'b0);
    // R12 back-pressure with sparse mask
    run_event(32'hA5A5_0F0F, 2, 1, 1'b0);
    run_event(32'h8000_0001, 3, 2, 1'b0);
    // R8 empty event
    run_event(32'h0000_0000, 4, 1, 1'b0);
    // R9 gap: two counted-only triggers
    skip_trig();
    skip_trig();
    run_event(32'h0001_0000, 5, 0, 1'b0);
    // R13 trigger during a frame
    run_event(32'hFFFF_FFFF, 6, 1, 1'b1);
    run_event(32'h0000_0100, 7, 0, 1'b0);
    // R11 counter clear
    evt_cnt_clr = 1'b1;
    @(negedge clk);
    evt_cnt_clr = 1'b0;
    exp_cnt = '0;
    run_event(32'h0F0F_F0F0, 8, 2, 1'b0);
    // single-channel sweep: every slot position (R7)
    for (int b = 0; b < N; b++) run_event(32'h1 << b, 10 + b, b % 3, 1'b0);
    // pseudo-random masks
    begin
      logic [31:0] lf;
      lf = 32'h1234_5678;
      for (int e = 0; e < 24; e++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        if (e % 4 == 0) skip_trig();
        run_event(lf, 50 + e, e % 3, 1'b0);
      end
    end

    // R10 wrap on a 4-bit counter: 17 counted-only triggers, then a stored one
    for (int t = 0; t < 17; t++) begin
      s_store = 1'b0; s_trig = 1'b1;
      @(negedge clk);
      s_trig = 1'b0;
    end
    s_store = 1'b1; s_trig = 1'b1;
    @(negedge clk);
    s_trig = 1'b0;
    begin
      int to;
      to = 0;
      while (!(s_valid && s_last) && to < 50) begin
        @(negedge clk);
        to++;
      end
    end
    chk("R10 wrapped trailer", s_data, {5'h00, 3'b100, 24'd1});

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule